// File: doc/BRIEF.md
# Serial/Parallel FIFO Exit Register

This block is the last stage of a narrow fall-through FIFO. It takes the word sitting in the bottom stack slot, holds it for a parallel reader, and can also hand it out one bit at a time. Its `out_ready` flag goes HIGH while the register holds an unread word, and goes LOW once that word has been consumed. The parallel port consumes a word when its pull level drops. The serial port consumes a word once all of its bits have been shifted out.

The pull, serial-request, shift-clock and peer-permit inputs come from slow or external sources, so they pass through synchronisers first. A falling edge of the shift clock becomes a one-cycle shift event. When several stages sit side by side to make a wider word, the one strapped as leader raises `out_ready` as soon as it loads. A follower holds the flag LOW until its peer-permit input is HIGH. A one-cycle take strobe tells the stack that it can drop its bottom word. Master clear empties the register but does not clear the data it holds.

Top module: `fos_output_stage`

## Requirements
- R1: After `rst_n` or `mr_n` is sampled LOW, `out_ready` and `qs_en` are LOW and `stk_take` is LOW; `mr_n` does not alter `q`.
- R2: Each of `pull_par`, `ser_req_n`, `shift_clk` and `peer_ok` is seen through SYNC_STAGES flip-flops. When the register is empty, `stk_valid` is HIGH, the synchronised `pull_par` is HIGH and the synchronised `ser_req_n` is LOW, `stk_take` is HIGH for one cycle. At the next edge `stk_word` is captured into both `q` and the shifter.
- R3: The pull input acts on its level, not on an edge. A word that reaches the bottom slot while `pull_par` is already HIGH is loaded during that same HIGH interval.
- R4: While the register is full, no further word is taken, even if `pull_par` stays HIGH and the stack holds more words.
- R5: If `pull_par` goes HIGH and returns LOW while the stack is empty, `out_ready` stays LOW and `stk_take` never pulses.
- R6: A falling edge of the synchronised `pull_par` empties a full register. `out_ready` goes LOW at that edge, and `q` keeps the last word until the next load.
- R7: On a load, `qs_en` goes HIGH and `qs` presents bit 0 of the word. Each synchronised HIGH-to-LOW transition of `shift_clk` then moves the next higher bit onto `qs`.
- R8: The WORD_W-th shift empties the register: `out_ready` and `qs_en` fall together. If `ser_req_n` follows `out_ready` and `pull_par` stays HIGH, the next stack word is then loaded without any other stimulus.
- R9: When `master_sel` is HIGH, `out_ready` rises at the same edge as the load. When `master_sel` is LOW, `out_ready` stays LOW after the load until the synchronised `peer_ok` is HIGH, and then stays HIGH until the register empties.
- R10: `q_en` follows `par_oe`.
- R11: While the synchronised `ser_req_n` is HIGH, no word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_n | input | 1 | Synchronous active-low master clear (empties the register, keeps data) |
| master_sel | input | 1 | HIGH: leader stage; LOW: follower gated by `peer_ok` |
| pull_par | input | 1 | Level pull request; its fall consumes a parallel word |
| ser_req_n | input | 1 | Active-low serial load request |
| shift_clk | input | 1 | Serial shift clock; falling edges shift |
| peer_ok | input | 1 | Permit from the neighbouring stage for a follower |
| par_oe | input | 1 | Parallel output enable |
| stk_valid | input | 1 | Bottom stack slot holds a word |
| stk_word | input | WORD_W | Bottom stack word |
| stk_take | output | 1 | One-cycle strobe: bottom word is taken |
| q | output | WORD_W | Parallel data |
| q_en | output | 1 | Drive enable for `q` |
| qs | output | 1 | Serial data bit |
| qs_en | output | 1 | Drive enable for `qs` |
| out_ready | output | 1 | HIGH while an unread word is held |

## Verification
The bench builds the block with WORD_W = 4 and SYNC_STAGES = 2. The four-bit word keeps a whole serial drain within about twenty cycles, so the auto-reload that follows the last shift can be reached several times. Two synchroniser stages give a fixed three-edge delay from an input change to the register update. The reference model therefore also exercises the collisions around that delay: a pull that falls while a shift is pending, a request that is still HIGH in the synchroniser when the register empties, and a follower whose permit arrives late.

// File: rtl/fos_pkg.sv
// Package fos_pkg: shared constants for the FIFO exit stage.
// Assumes: the four asynchronous controls are carried as one vector.
package fos_pkg;
    // Bit positions of the asynchronous control vector.
    localparam int CTL_W    = 4;
    localparam int CTL_PULL = 0;
    localparam int CTL_SREQ = 1;
    localparam int CTL_SCLK = 2;
    localparam int CTL_PEER = 3;
endpackage

// File: rtl/fos_sync.sv
// fos_sync: per-bit flip-flop chain that brings asynchronous levels into
// the clk domain. Assumes STAGES >= 1; output is the last stage of each chain.
module fos_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            if (STAGES == 1) begin : g_one
                // Single-stage capture of the input level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain <= '0;
                    else        chain <= d[i];
                end
            end else begin : g_many
                // Shift the input level through the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain <= '0;
                    else        chain <= {chain[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fos_shift_reg.sv
// fos_shift_reg: holds one word for parallel reading, shifts a copy out
// LSB first, and tracks whether an unread word is present.
// Assumes load is only raised while empty; clr empties but keeps data.
module fos_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         drop,
    input  logic         shift,
    output logic         full,
    output logic         full_nxt,
    output logic         ser_bit,
    output logic [W-1:0] hold
);
    localparam int CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    // Next occupancy: load fills, parallel drop or final shift empties.
    always_comb begin
        full_nxt = full;
        if (clr)                                   full_nxt = 1'b0;
        else if (load)                             full_nxt = 1'b1;
        else if (full && drop)                     full_nxt = 1'b0;
        else if (full && shift && (cnt == LAST))   full_nxt = 1'b0;
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) full <= 1'b0;
        else        full <= full_nxt;
    end

    // Data, shift contents and shift count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            hold <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            sh   <= word;
            hold <= word;
            cnt  <= '0;
        end else if (full && !drop && shift) begin
            sh  <= {1'b0, sh[W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end

    assign ser_bit = sh[0];
endmodule

// File: rtl/fos_flag_gate.sv
// fos_flag_gate: produces the ready flag. A leader raises it with the load;
// a follower waits for the peer permit. It falls when the register empties.
// Assumes full_nxt is already LOW during a master clear.
module fos_flag_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic full_nxt,
    input  logic master,
    input  logic peer_ok,
    output logic ready
);
    // Hold the flag once raised; drop it with the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= full_nxt & (master | peer_ok | ready);
    end
endmodule

// File: rtl/fos_output_stage.sv
// fos_output_stage: exit register of a fall-through FIFO with parallel and
// serial drain. Assumes the stack presents stk_word/stk_valid synchronous to
// clk and drops its bottom word on the edge where stk_take is HIGH.
module fos_output_stage #(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_n,
    input  logic              master_sel,
    input  logic              pull_par,
    input  logic              ser_req_n,
    input  logic              shift_clk,
    input  logic              peer_ok,
    input  logic              par_oe,
    input  logic              stk_valid,
    input  logic [WORD_W-1:0] stk_word,
    output logic              stk_take,
    output logic [WORD_W-1:0] q,
    output logic              q_en,
    output logic              qs,
    output logic              qs_en,
    output logic              out_ready
);
    import fos_pkg::*;

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic pull_d, sclk_d;
    logic full, full_nxt;
    logic pull_fall, sclk_fall, load;

    assign ctl_raw[CTL_PULL] = pull_par;
    assign ctl_raw[CTL_SREQ] = ser_req_n;
    assign ctl_raw[CTL_SCLK] = shift_clk;
    assign ctl_raw[CTL_PEER] = peer_ok;

    fos_sync #(.N(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_d <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            pull_d <= ctl_s[CTL_PULL];
            sclk_d <= ctl_s[CTL_SCLK];
        end
    end

    assign pull_fall = pull_d & ~ctl_s[CTL_PULL];
    assign sclk_fall = sclk_d & ~ctl_s[CTL_SCLK];
    assign load      = mr_n & ~full & stk_valid & ctl_s[CTL_PULL] & ~ctl_s[CTL_SREQ];

    fos_shift_reg #(.W(WORD_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~mr_n),
        .load     (load),
        .word     (stk_word),
        .drop     (pull_fall),
        .shift    (sclk_fall),
        .full     (full),
        .full_nxt (full_nxt),
        .ser_bit  (qs),
        .hold     (q)
    );

    fos_flag_gate u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_nxt (full_nxt),
        .master   (master_sel),
        .peer_ok  (ctl_s[CTL_PEER]),
        .ready    (out_ready)
    );

    assign stk_take = load;
    assign qs_en    = full;
    assign q_en     = par_oe;
endmodule

// File: rtl/fos_output_stage_chk.sv
// fos_output_stage_chk: temporal properties of the exit stage, bound to it.
module fos_output_stage_chk #(
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mr_n,
    input logic              stk_valid,
    input logic              stk_take,
    input logic              qs_en,
    input logic              out_ready,
    input logic [WORD_W-1:0] q
);
    // R1
    clear_empties_chk: assert property (@(posedge clk) (!rst_n || !mr_n) |=> (!out_ready && !qs_en));
    // R2
    take_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n) stk_take |-> stk_valid);
    // R2
    take_fills_chk: assert property (@(posedge clk) disable iff (!rst_n) stk_take |=> qs_en);
    // R4
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n) stk_take |-> !qs_en);
    // R6
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n) !$past(stk_take) |-> $stable(q));
    // R8
    empty_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(qs_en) |-> !out_ready);
    // R9
    ready_only_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n) out_ready |-> qs_en);
endmodule

bind fos_output_stage fos_output_stage_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr_n      (mr_n),
    .stk_valid (stk_valid),
    .stk_take  (stk_take),
    .qs_en     (qs_en),
    .out_ready (out_ready),
    .q         (q)
);

// File: tb/fos_output_stage_test.sv
module fos_output_stage_test;
    localparam int W = 4;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0, mr_n = 1'b1, master_sel = 1'b1;
    logic pull_par = 1'b0, ser_req_n = 1'b0, shift_clk = 1'b0, peer_ok = 1'b0, par_oe = 1'b0;
    logic stk_valid = 1'b0;
    logic [W-1:0] stk_word = '0;
    logic stk_take, q_en, qs, qs_en, out_ready;
    logic [W-1:0] q;

    int checks = 0, errors = 0;
    bit done = 0;
    bit tie_req = 0;
    string cur = "R1";

    // behavioural reference state
    logic [W-1:0] stk[$];
    logic [S-1:0] p_pull = '0, p_sreq = '0, p_sclk = '0, p_peer = '0;
    bit m_pull_prev = 0, m_sclk_prev = 0, m_full = 0, m_ready = 0;
    logic [W-1:0] m_sh = '0, m_hold = '0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    fos_output_stage #(.WORD_W(W), .SYNC_STAGES(S)) uut (
        .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .master_sel(master_sel),
        .pull_par(pull_par), .ser_req_n(ser_req_n), .shift_clk(shift_clk),
        .peer_ok(peer_ok), .par_oe(par_oe), .stk_valid(stk_valid),
        .stk_word(stk_word), .stk_take(stk_take), .q(q), .q_en(q_en),
        .qs(qs), .qs_en(qs_en), .out_ready(out_ready)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_load();
        return mr_n && !m_full && (stk.size() > 0) && p_pull[S-1] && !p_sreq[S-1];
    endfunction

    task automatic step();
        bit ld, pf, sf;
        @(negedge clk);
        chk({cur, " take"}, int'(stk_take), int'(rst_n ? model_load() : 1'b0));
        @(posedge clk);
        if (!rst_n) begin
            p_pull = '0; p_sreq = '0; p_sclk = '0; p_peer = '0;
            m_pull_prev = 0; m_sclk_prev = 0; m_full = 0; m_ready = 0;
            m_sh = '0; m_hold = '0; m_cnt = 0;
        end else begin
            ld = model_load();
            pf = m_pull_prev && !p_pull[S-1];
            sf = m_sclk_prev && !p_sclk[S-1];
            if (!mr_n) begin
                m_full = 0; m_cnt = 0;
            end else if (ld) begin
                m_sh = stk.pop_front(); m_hold = m_sh; m_cnt = 0; m_full = 1;
            end else if (m_full && pf) begin
                m_full = 0;
            end else if (m_full && sf) begin
                m_sh = m_sh >> 1; m_cnt++;
                if (m_cnt == W) m_full = 0;
            end
            m_ready = m_full && (master_sel || p_peer[S-1] || m_ready);
            m_pull_prev = p_pull[S-1];
            m_sclk_prev = p_sclk[S-1];
            p_pull = {p_pull[S-2:0], pull_par};
            p_sreq = {p_sreq[S-2:0], ser_req_n};
            p_sclk = {p_sclk[S-2:0], shift_clk};
            p_peer = {p_peer[S-2:0], peer_ok};
        end
        #1;
        chk({cur, " out_ready"}, int'(out_ready), int'(m_ready));
        chk({cur, " qs_en"}, int'(qs_en), int'(m_full));
        if (m_full) chk({cur, " qs"}, int'(qs), int'(m_sh[0]));
        chk({cur, " q"}, int'(q), int'(m_hold));
        chk({cur, " q_en"}, int'(q_en), int'(par_oe));
        stk_valid = stk.size() > 0;
        stk_word  = (stk.size() > 0) ? stk[0] : '0;
        if (tie_req) ser_req_n = out_ready;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic push(logic [W-1:0] w);
        stk.push_back(w);
        stk_valid = 1'b1;
        stk_word  = stk[0];
    endtask

    task automatic pulse_shift();
        shift_clk = 1'b1; run(3);
        shift_clk = 1'b0; run(3);
    endtask

    initial begin
        // R1: reset state
        cur = "R1";
        run(3);
        rst_n = 1'b1;
        run(2);
        chk("R1 ready after reset", int'(out_ready), 0);
        chk("R1 serial disabled after reset", int'(qs_en), 0);

        // R5: pull with empty stack
        cur = "R5";
        pull_par = 1'b1; run(6);
        pull_par = 1'b0; run(6);
        chk("R5 ready stays low", int'(out_ready), 0);

        // R3: word arrives while pull already HIGH
        cur = "R3";
        pull_par = 1'b1; run(4);
        push(4'hA); run(4);
        chk("R3 late word loaded", int'(q), 'hA);
        chk("R3 ready high", int'(out_ready), 1);

        // R4: more words, pull stays HIGH
        cur = "R4";
        push(4'h5); push(4'h3); run(8);
        chk("R4 no second load", int'(q), 'hA);

        // R6: pull falls, data held
        cur = "R6";
        pull_par = 1'b0; run(6);
        chk("R6 ready low", int'(out_ready), 0);
        chk("R6 q holds", int'(q), 'hA);

        // R2: next pull loads next word
        cur = "R2";
        pull_par = 1'b1; run(6);
        chk("R2 next word", int'(q), 'h5);
        pull_par = 1'b0; run(6);

        // R11: serial request HIGH blocks load
        cur = "R11";
        ser_req_n = 1'b1; pull_par = 1'b1; run(8);
        chk("R11 no load", int'(out_ready), 0);
        chk("R11 q unchanged", int'(q), 'h5);
        ser_req_n = 1'b0; run(6);
        chk("R11 load after release", int'(q), 'h3);
        pull_par = 1'b0; run(6);

        // R10: parallel enable
        cur = "R10";
        par_oe = 1'b1; run(2);
        chk("R10 q_en on", int'(q_en), 1);
        par_oe = 1'b0; run(2);
        chk("R10 q_en off", int'(q_en), 0);

        // R7/R8: serial drain with request tied to ready
        cur = "R7";
        push(4'h6); push(4'h9);
        tie_req = 1; ser_req_n = 1'b0; pull_par = 1'b1; run(6);
        chk("R7 serial enabled", int'(qs_en), 1);
        chk("R7 first bit", int'(qs), 0);
        pulse_shift(); chk("R7 bit1", int'(qs), 1);
        pulse_shift(); chk("R7 bit2", int'(qs), 1);
        pulse_shift(); chk("R7 bit3", int'(qs), 0);
        cur = "R8";
        pulse_shift(); run(6);
        chk("R8 auto reload", int'(q), 'h9);
        chk("R8 ready again", int'(out_ready), 1);
        for (int b = 0; b < W; b++) pulse_shift();
        run(4);
        chk("R8 drained", int'(qs_en), 0);
        tie_req = 0; ser_req_n = 1'b0; pull_par = 1'b0; run(6);

        // R9: follower waits for peer permit
        cur = "R9";
        master_sel = 1'b0; peer_ok = 1'b0;
        push(4'hC); pull_par = 1'b1; run(8);
        chk("R9 loaded", int'(qs_en), 1);
        chk("R9 ready held low", int'(out_ready), 0);
        peer_ok = 1'b1; run(4);
        chk("R9 ready after permit", int'(out_ready), 1);
        peer_ok = 1'b0; run(3);
        chk("R9 ready kept", int'(out_ready), 1);

        // R1: master clear
        cur = "R1";
        mr_n = 1'b0; run(2);
        chk("R1 clear ready", int'(out_ready), 0);
        chk("R1 clear serial", int'(qs_en), 0);
        chk("R1 clear keeps q", int'(q), 'hC);
        mr_n = 1'b1; pull_par = 1'b0; master_sel = 1'b1; run(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule